// File: doc/BRIEF.md
# Image Sensor Pixel Capture Controller

This block takes the parallel output of a CMOS image sensor and stores the active pixels in an on-chip frame buffer. The sensor supplies a pixel clock, a frame qualifier, a line qualifier and an 8-bit pixel bus. On every falling edge of the pixel clock the controller looks at both qualifiers. When both are high, it writes the pixel on the bus into the buffer at the next address in sequence.

The buffer has a second port with its own clock. Another agent, such as a processor bus bridge, can read any word at any time without disturbing capture. Each frame is written from word 0 upward. The block raises a one-period pulse when a captured frame ends. It holds a sticky flag once the buffer is full, and all pixels after that are dropped until the next frame begins.

A frame that is already running when reset is released is skipped in full. Capture waits until the frame qualifier has been seen low, so a frame is never stored from part way through.

Top module: `pcap_top`

## Requirements
- R1: A pixel is stored only when frame-valid and line-valid are both high at a falling edge of `sens_pclk`. Stored pixels go to consecutive ascending word addresses.
- R2: The first pixel of each frame goes to word 0. This holds even when frame-valid and line-valid rise in the same sample.
- R3: A sample with line-valid high and frame-valid low is not stored. A sample with frame-valid high and line-valid low is not stored either.
- R4: Once word 1023 has been written, `buf_full` is high after that same falling edge. Every later pixel of the frame is dropped and no word changes.
- R5: `buf_full` stays high through the end of the frame. It returns low after the falling edge at which the next frame's frame-valid is first seen high.
- R6: `frame_done` is high for exactly one pixel-clock period. It starts at the falling edge where frame-valid is first seen low after a captured frame.
- R7: If frame-valid is high when reset is released, that frame is ignored: no pixel is stored and no `frame_done` pulse is given.
- R8: `rd_data` shows the buffer word at `rd_addr` after the next rising edge of `rd_clk`.
- R9: While reset is asserted, `frame_done` and `buf_full` are low. The controller is only ever in one of its four defined states, and any other encoding returns it to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sens_pclk | input | 1 | Sensor pixel clock; sampling on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset of the capture side |
| sens_frame | input | 1 | Frame-valid qualifier from the sensor |
| sens_line | input | 1 | Line-valid qualifier from the sensor |
| sens_pixel | input | 8 | Pixel data bus |
| rd_clk | input | 1 | Clock of the buffer read port |
| rd_addr | input | 10 | Word address to read |
| rd_data | output | 8 | Word read from the buffer, registered |
| frame_done | output | 1 | One-period pulse at the end of a captured frame |
| buf_full | output | 1 | Sticky flag: the last buffer word has been written |

## Verification
Two things can happen on the same falling edge: a frame starts, which resets the address and clears the full flag, and the first pixel is written. The bench provokes this by raising both qualifiers in one sample. It then judges the result by reading back word 0 and word 1 through the read port.

A second coincidence is the write of word 1023 and the setting of `buf_full`. The bench checks the flag right after that edge, and again one edge earlier. It then sweeps all 1024 words to confirm that the overflow pixels were dropped.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

    // Three-bit encoding leaves four codes unused; they fall back to idle.
    typedef enum logic [2:0] {
        CS_IDLE       = 3'd0,
        CS_WAIT_FRAME = 3'd1,
        CS_WAIT_LINE  = 3'd2,
        CS_CAPTURE    = 3'd3
    } cap_state_e;

endpackage

// File: rtl/pcap_frame_ram.sv
module pcap_frame_ram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 10
) (
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rd_data_q;

    // Write port samples on the falling edge, where sensor data is stable.
    always_ff @(negedge wr_clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge rd_clk) begin
        rd_data_q <= mem_q[rd_addr];
    end

    assign rd_data = rd_data_q;

endmodule

// File: rtl/pcap_write_ctrl.sv
module pcap_write_ctrl
    import pcap_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              pclk,
    input  logic              rst_n,
    input  logic              fval_i,
    input  logic              lval_i,
    output logic              we_o,
    output logic [ADDR_W-1:0] waddr_o,
    output logic              full_o,
    output logic              done_o
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    typedef struct packed {
        cap_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic              full;
        logic              done;
    } ctrl_t;

    ctrl_t             cur_q;
    ctrl_t             nxt_d;
    logic              we_d;
    logic [ADDR_W-1:0] waddr_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        we_d       = 1'b0;
        waddr_d    = cur_q.addr;
        case (cur_q.st)
            CS_IDLE: begin
                // Only arm once the frame qualifier is seen low.
                if (!fval_i) begin
                    nxt_d.st = CS_WAIT_FRAME;
                end
            end
            CS_WAIT_FRAME: begin
                if (fval_i) begin
                    nxt_d.full = 1'b0;
                    nxt_d.addr = '0;
                    waddr_d    = '0;
                    if (lval_i) begin
                        we_d     = 1'b1;
                        nxt_d.st = CS_CAPTURE;
                    end else begin
                        nxt_d.st = CS_WAIT_LINE;
                    end
                end
            end
            CS_WAIT_LINE: begin
                if (!fval_i) begin
                    nxt_d.done = 1'b1;
                    nxt_d.st   = CS_WAIT_FRAME;
                end else if (lval_i) begin
                    we_d     = !cur_q.full;
                    nxt_d.st = CS_CAPTURE;
                end
            end
            CS_CAPTURE: begin
                if (!fval_i) begin
                    nxt_d.done = 1'b1;
                    nxt_d.st   = CS_WAIT_FRAME;
                end else if (lval_i) begin
                    we_d = !cur_q.full;
                end else begin
                    nxt_d.st = CS_WAIT_LINE;
                end
            end
            default: begin
                nxt_d.st = CS_IDLE;
            end
        endcase

        if (we_d) begin
            if (waddr_d == LAST_ADDR) begin
                nxt_d.full = 1'b1;
            end else begin
                nxt_d.addr = waddr_d + 1'b1;
            end
        end
    end

    always_ff @(negedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: CS_IDLE, addr: '0, full: 1'b0, done: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign we_o    = we_d;
    assign waddr_o = waddr_d;
    assign full_o  = cur_q.full;
    assign done_o  = cur_q.done;

    AST_WRITE_QUALIFIED: assert property (@(negedge pclk) disable iff (!rst_n)
        we_d |-> (fval_i && lval_i)) else $error("write without both qualifiers"); // R1

    AST_FRAME_START_ZERO: assert property (@(negedge pclk) disable iff (!rst_n)
        (cur_q.st == CS_WAIT_FRAME && fval_i && lval_i) |-> (we_d && waddr_d == '0))
        else $error("frame start did not write word 0"); // R2

    AST_NO_WRITE_WHEN_FULL: assert property (@(negedge pclk) disable iff (!rst_n)
        (cur_q.full && cur_q.st != CS_WAIT_FRAME) |-> !we_d)
        else $error("write while full"); // R4

    AST_FULL_STICKY: assert property (@(negedge pclk) disable iff (!rst_n)
        (cur_q.full && cur_q.st != CS_WAIT_FRAME) |=> cur_q.full)
        else $error("full dropped inside a frame"); // R5

    AST_DONE_ONE_CYCLE: assert property (@(negedge pclk) disable iff (!rst_n)
        cur_q.done |=> !cur_q.done) else $error("done longer than one period"); // R6

    AST_STATE_LEGAL: assert property (@(negedge pclk) disable iff (!rst_n)
        (cur_q.st == CS_IDLE || cur_q.st == CS_WAIT_FRAME ||
         cur_q.st == CS_WAIT_LINE || cur_q.st == CS_CAPTURE))
        else $error("illegal state"); // R9

endmodule

// File: rtl/pcap_top.sv
module pcap_top #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 10
) (
    input  logic              sens_pclk,
    input  logic              rst_n,
    input  logic              sens_frame,
    input  logic              sens_line,
    input  logic [DATA_W-1:0] sens_pixel,
    input  logic              rd_clk,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              frame_done,
    output logic              buf_full
);

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;

    pcap_write_ctrl #(
        .ADDR_W (ADDR_W)
    ) u_ctrl (
        .pclk    (sens_pclk),
        .rst_n   (rst_n),
        .fval_i  (sens_frame),
        .lval_i  (sens_line),
        .we_o    (wr_en),
        .waddr_o (wr_addr),
        .full_o  (buf_full),
        .done_o  (frame_done)
    );

    pcap_frame_ram #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_ram (
        .wr_clk  (sens_pclk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (sens_pixel),
        .rd_clk  (rd_clk),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    AST_RESET_OUTPUTS_LOW: assert property (@(negedge sens_pclk)
        !rst_n |-> (!frame_done && !buf_full)) else $error("outputs high in reset"); // R9

endmodule

// File: tb/pcap_top_bench.sv
module pcap_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fval = 1'b0;
    logic       lval = 1'b0;
    logic [7:0] pix = 8'h00;
    logic [9:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       frame_done;
    logic       buf_full;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pcap_top u_pcap_top (
        .sens_pclk  (clk),
        .rst_n      (rst_n),
        .sens_frame (fval),
        .sens_line  (lval),
        .sens_pixel (pix),
        .rd_clk     (clk),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .frame_done (frame_done),
        .buf_full   (buf_full)
    );

    function automatic int pat_a(int i);
        return (i * 37 + 11) & 255;
    endfunction

    function automatic int pat_b(int i);
        return (i ^ 8'hC3) & 255;
    endfunction

    function automatic int pat_c(int i);
        return (i * 5 + (i >> 3)) & 255;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one sample: set up after a rising edge, settle after the falling edge.
    task automatic sample(bit f, bit l, int d);
        @(posedge clk);
        #1;
        fval = f;
        lval = l;
        pix  = d[7:0];
        @(negedge clk);
        #1;
    endtask

    task automatic read_word(int a, output int v);
        rd_addr = a[9:0];
        @(posedge clk);
        #1;
        v = int'(rd_data);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v;
        int k;
        // A frame is already running while reset is held.
        fval = 1'b1;
        lval = 1'b1;
        pix  = 8'h99;
        repeat (3) @(negedge clk);
        #1;
        chk("R9 reset frame_done", int'(frame_done), 0);
        chk("R9 reset buf_full", int'(buf_full), 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R7: leftover frame ignored.
        for (int i = 0; i < 4; i++) sample(1, 1, 8'hAA);
        sample(0, 0, 0);
        chk("R7 no done for skipped frame", int'(frame_done), 0);
        sample(0, 0, 0);

        // Frame A: both qualifiers rise together (R2), 3 lines of 5, blanking in between.
        k = 0;
        for (int ln = 0; ln < 3; ln++) begin
            for (int p = 0; p < 5; p++) begin
                sample(1, 1, pat_a(k));
                k++;
            end
            sample(1, 0, 8'hEE);
            sample(1, 0, 8'hEF);
        end
        sample(0, 0, 8'h11);
        chk("R6 done on frame end", int'(frame_done), 1);
        sample(0, 1, 8'h33);
        chk("R6 done one period only", int'(frame_done), 0);
        sample(0, 0, 0);
        for (int i = 0; i < 15; i++) begin
            read_word(i, v);
            chk("R1 R3 R8 frame A word", v, pat_a(i));
        end

        // Frame B: line rises after frame; restart at word 0 (R2).
        sample(1, 0, 8'h77);
        for (int i = 0; i < 4; i++) sample(1, 1, pat_b(i));
        sample(1, 0, 8'h55);
        sample(0, 0, 0);
        chk("R6 done frame B", int'(frame_done), 1);
        for (int i = 0; i < 4; i++) begin
            read_word(i, v);
            chk("R2 frame B restarts at 0", v, pat_b(i));
        end
        read_word(4, v);
        chk("R1 word 4 untouched by short frame", v, pat_a(4));

        // Frame C: overflow past the last word.
        sample(1, 0, 0);
        for (int i = 0; i < 1030; i++) begin
            sample(1, 1, pat_c(i));
            if (i == 1022) chk("R4 not full before last word", int'(buf_full), 0);
            if (i == 1023) chk("R4 full after last word", int'(buf_full), 1);
        end
        chk("R5 full held in frame", int'(buf_full), 1);
        sample(0, 0, 0);
        chk("R6 done frame C", int'(frame_done), 1);
        chk("R5 full held past frame end", int'(buf_full), 1);
        sample(0, 0, 0);
        for (int i = 0; i < 1024; i++) begin
            read_word(i, v);
            chk("R4 R8 frame C sweep", v, pat_c(i));
        end
        chk("R5 full held while idle", int'(buf_full), 1);

        // Frame D: full clears on frame start.
        sample(1, 0, 0);
        chk("R5 full cleared at frame start", int'(buf_full), 0);
        sample(1, 1, 8'h42);
        sample(0, 0, 0);
        sample(0, 0, 0);
        read_word(0, v);
        chk("R2 frame D word 0", v, 8'h42);
        read_word(1, v);
        chk("R4 frame D word 1 kept", v, pat_c(1));
        chk("R9 controller still legal and capturing", int'(buf_full), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule